// File: doc/BRIEF.md
# Lockstep Long-Word Issue Controller

This block sits between instruction fetch and a row of five functional units in a statically scheduled machine. Each cycle it holds one long instruction word and hands every slot of that word to its own unit at the same time: two memory-reference units, two floating-point units and one integer/branch unit. The compiler has already scheduled the word, so the block does no dependence checking between the operations inside it. Slots the compiler left empty reach their units as an all-zero no-op with no valid strobe.

The machine runs in lockstep. A stall request from any unit, or a data-cache miss from either memory unit, freezes the held word, withholds every valid strobe and drops the fetch ready signal, so no slot ever runs ahead of the others. A taken branch reported by the integer/branch unit redirects fetch and turns the wrong-path word that arrives in the same cycle into a word of no-ops. Two running counters give the number of issued words and the number of real operations, from which slot utilisation follows.

Top module: `vliw_issue_ctrl`

## Requirements
- R1: After reset, every slot strobe is low, every slot operation output is zero and both counters read zero.
- R2: Slot i of the fetched word occupies bits i*33 to i*33+32; bit i*33+32 is its valid flag and the lower 32 bits are its operation. Slot 0 and 1 are memory references, 2 and 3 are floating point, 4 is integer/branch. A word accepted in cycle n drives all of its valid slots, each on its own output lane, together in cycle n+1.
- R3: A slot whose valid flag is clear drives an all-zero operation and no strobe.
- R4: While any bit of unit_stall is high, global_stall is high, fetch_ready is low, no strobe is high and the held word is kept; it issues once the stall clears.
- R5: A miss report on either bit of miss_stall has the same whole-machine effect as a unit stall.
- R6: A word is accepted only in a cycle where fetch_valid is high and no stall is present; a non-stalled cycle with fetch_valid low leaves an empty word, so the next cycle strobes nothing.
- R7: In a non-stalled cycle with br_taken high, redirect_valid is high and redirect_pc equals br_target in that cycle, and the word accepted in that cycle is replaced by all no-ops. br_taken during a stall causes no redirect and no flush.
- R8: In each non-stalled cycle with at least one strobe, issued_cnt rises by one and op_cnt rises by the number of strobes; both wrap modulo 2 to the counter width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch side presents a word |
| fetch_word | input | 165 | Five 33-bit slot fields, slot 0 lowest |
| fetch_ready | output | 1 | Word accepted this cycle when fetch_valid is high |
| unit_stall | input | 5 | Per-unit stall requests |
| miss_stall | input | 2 | Data-cache miss from the memory units |
| br_taken | input | 1 | Taken branch from the integer/branch unit |
| br_target | input | 32 | Branch destination address |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Redirect address |
| slot_op | output | 160 | Per-slot operations, 32 bits each, slot 0 lowest |
| slot_vld | output | 5 | Per-slot dispatch strobes |
| global_stall | output | 1 | Machine-wide freeze |
| issued_cnt | output | 16 | Issued word count |
| op_cnt | output | 16 | Issued operation count |

## Verification
The bench drives stalls that last several cycles on single units and on the miss inputs, and checks that the frozen word is neither lost nor dispatched twice; a design that leaked one strobe during a freeze would double-issue an operation. It raises a branch both in a free cycle and inside a stall, where a flush-while-frozen design would throw away the held word. Words with every slot full, with every slot empty and with mixed flags check lane placement and that an empty slot shows a zero operation rather than stale bits. The counters run past their wrap point with a reduced width, catching a miscount or a saturating counter.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;
   localparam int unsigned DEF_SLOTS     = 5;
   localparam int unsigned DEF_MEM_SLOTS = 2;
   localparam int unsigned DEF_OP_W      = 32;
   localparam int unsigned DEF_ADDR_W    = 32;
   localparam int unsigned DEF_CNT_W     = 16;

   // one slot field is the operation plus its valid flag
   function automatic int unsigned field_w(int unsigned op_w);
      return op_w + 1;
   endfunction
endpackage

// File: rtl/vliw_stall_merge.sv
module vliw_stall_merge #(
   parameter int unsigned SLOTS     = vliw_issue_pkg::DEF_SLOTS,
   parameter int unsigned MEM_SLOTS = vliw_issue_pkg::DEF_MEM_SLOTS
) (
   input  logic [SLOTS-1:0]     unit_stall,
   input  logic [MEM_SLOTS-1:0] miss_stall,
   output logic                 freeze
);
   always_comb freeze = (|unit_stall) | (|miss_stall);
endmodule

// File: rtl/vliw_word_reg.sv
module vliw_word_reg #(
   parameter int unsigned SLOTS = vliw_issue_pkg::DEF_SLOTS,
   parameter int unsigned OP_W  = vliw_issue_pkg::DEF_OP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  advance,
   input  logic                  take,
   input  logic                  squash,
   input  logic [SLOTS*OP_W-1:0] in_op,
   input  logic [SLOTS-1:0]      in_vld,
   output logic [SLOTS*OP_W-1:0] op_q,
   output logic [SLOTS-1:0]      vld_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= '0;
         vld_q <= '0;
      end else if (advance) begin
         if (take && !squash) begin
            op_q  <= in_op;
            vld_q <= in_vld;
         end else begin
            op_q  <= '0;
            vld_q <= '0;
         end
      end
   end
endmodule

// File: rtl/vliw_issue_count.sv
module vliw_issue_count #(
   parameter int unsigned SLOTS = vliw_issue_pkg::DEF_SLOTS,
   parameter int unsigned CNT_W = vliw_issue_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] strobe,
   output logic [CNT_W-1:0] words,
   output logic [CNT_W-1:0] ops
);
   localparam int unsigned POP_W = $clog2(SLOTS + 1);

   logic [POP_W-1:0] pop;

   always_comb begin
      pop = '0;
      for (int i = 0; i < SLOTS; i++) pop = pop + POP_W'(strobe[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         words <= '0;
         ops   <= '0;
      end else if (|strobe) begin
         words <= words + CNT_W'(1);
         ops   <= ops + CNT_W'(pop);
      end
   end
endmodule

// File: rtl/vliw_issue_ctrl.sv
module vliw_issue_ctrl #(
   parameter int unsigned SLOTS     = vliw_issue_pkg::DEF_SLOTS,
   parameter int unsigned MEM_SLOTS = vliw_issue_pkg::DEF_MEM_SLOTS,
   parameter int unsigned OP_W      = vliw_issue_pkg::DEF_OP_W,
   parameter int unsigned ADDR_W    = vliw_issue_pkg::DEF_ADDR_W,
   parameter int unsigned CNT_W     = vliw_issue_pkg::DEF_CNT_W,
   localparam int unsigned FLD_W    = vliw_issue_pkg::field_w(OP_W),
   localparam int unsigned WORD_W   = SLOTS * FLD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fetch_valid,
   input  logic [WORD_W-1:0]     fetch_word,
   output logic                  fetch_ready,
   input  logic [SLOTS-1:0]      unit_stall,
   input  logic [MEM_SLOTS-1:0]  miss_stall,
   input  logic                  br_taken,
   input  logic [ADDR_W-1:0]     br_target,
   output logic                  redirect_valid,
   output logic [ADDR_W-1:0]     redirect_pc,
   output logic [SLOTS*OP_W-1:0] slot_op,
   output logic [SLOTS-1:0]      slot_vld,
   output logic                  global_stall,
   output logic [CNT_W-1:0]      issued_cnt,
   output logic [CNT_W-1:0]      op_cnt
);
   initial begin
      assert (MEM_SLOTS < SLOTS) else $error("memory slots must leave room for other units");
      assert (OP_W >= 8) else $error("operation field too narrow");
      assert (CNT_W >= 2) else $error("counter too narrow");
   end

   logic [SLOTS*OP_W-1:0] in_op;
   logic [SLOTS-1:0]      in_vld;
   logic [SLOTS*OP_W-1:0] held_op;
   logic [SLOTS-1:0]      held_vld;

   // split the long word into per-slot lanes
   for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
      assign in_op[s*OP_W +: OP_W] = fetch_word[s*FLD_W +: OP_W];
      assign in_vld[s]             = fetch_word[s*FLD_W + OP_W];
   end

   vliw_stall_merge #(.SLOTS(SLOTS), .MEM_SLOTS(MEM_SLOTS)) u_merge (
      .unit_stall (unit_stall),
      .miss_stall (miss_stall),
      .freeze     (global_stall)
   );

   assign fetch_ready    = !global_stall;
   assign redirect_valid = br_taken && !global_stall;
   assign redirect_pc    = br_target;

   vliw_word_reg #(.SLOTS(SLOTS), .OP_W(OP_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (!global_stall),
      .take    (fetch_valid),
      .squash  (br_taken),
      .in_op   (in_op),
      .in_vld  (in_vld),
      .op_q    (held_op),
      .vld_q   (held_vld)
   );

   // per-slot drive: empty slots show the zero no-op encoding
   for (genvar s = 0; s < SLOTS; s++) begin : g_drive
      assign slot_op[s*OP_W +: OP_W] = held_vld[s] ? held_op[s*OP_W +: OP_W] : '0;
      assign slot_vld[s]             = held_vld[s] & !global_stall;
   end

   vliw_issue_count #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (slot_vld),
      .words  (issued_cnt),
      .ops    (op_cnt)
   );
endmodule

// File: rtl/vliw_issue_chk.sv
module vliw_issue_chk #(
   parameter int unsigned SLOTS     = 5,
   parameter int unsigned MEM_SLOTS = 2,
   parameter int unsigned OP_W      = 32,
   parameter int unsigned CNT_W     = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [SLOTS-1:0]      unit_stall,
   input logic [MEM_SLOTS-1:0]  miss_stall,
   input logic                  fetch_ready,
   input logic                  redirect_valid,
   input logic                  global_stall,
   input logic [SLOTS*OP_W-1:0] slot_op,
   input logic [SLOTS-1:0]      slot_vld,
   input logic [SLOTS-1:0]      held_vld,
   input logic [CNT_W-1:0]      issued_cnt,
   input logic [CNT_W-1:0]      op_cnt
);
   // R4
   unit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|unit_stall) |-> (slot_vld == '0 && !fetch_ready));

   // R5
   miss_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|miss_stall) |-> (slot_vld == '0 && !fetch_ready));

   // R4
   frozen_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      global_stall |=> $stable(slot_op));

   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> (slot_vld == '0));

   // R8
   word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !global_stall |=> (issued_cnt == $past(issued_cnt) + CNT_W'(|$past(slot_vld))));

   // R8
   op_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !global_stall |=> (op_cnt == $past(op_cnt) + CNT_W'($countones($past(slot_vld)))));

   for (genvar s = 0; s < SLOTS; s++) begin : g_nop
      // R3
      empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !held_vld[s] |-> (slot_op[s*OP_W +: OP_W] == '0 && !slot_vld[s]));
   end
endmodule

bind vliw_issue_ctrl vliw_issue_chk #(
   .SLOTS(SLOTS), .MEM_SLOTS(MEM_SLOTS), .OP_W(OP_W), .CNT_W(CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .unit_stall     (unit_stall),
   .miss_stall     (miss_stall),
   .fetch_ready    (fetch_ready),
   .redirect_valid (redirect_valid),
   .global_stall   (global_stall),
   .slot_op        (slot_op),
   .slot_vld       (slot_vld),
   .held_vld       (held_vld),
   .issued_cnt     (issued_cnt),
   .op_cnt         (op_cnt)
);

// File: tb/vliw_issue_ctrl_test.sv
module vliw_issue_ctrl_test;
   localparam int NS = 5, NM = 2, OW = 32, AW = 32, CW = 6;
   localparam int FW = OW + 1;

   logic clk = 0, rst_n = 0;
   logic fetch_valid = 0;
   logic [NS*FW-1:0] fetch_word = '0;
   logic fetch_ready;
   logic [NS-1:0] unit_stall = '0;
   logic [NM-1:0] miss_stall = '0;
   logic br_taken = 0;
   logic [AW-1:0] br_target = '0;
   logic redirect_valid;
   logic [AW-1:0] redirect_pc;
   logic [NS*OW-1:0] slot_op;
   logic [NS-1:0] slot_vld;
   logic global_stall;
   logic [CW-1:0] issued_cnt, op_cnt;

   int checks = 0, fails = 0;

   // model state
   logic [OW-1:0] m_op [NS];
   logic [NS-1:0] m_v;
   logic [CW-1:0] m_iss, m_ops;

   vliw_issue_ctrl #(.SLOTS(NS), .MEM_SLOTS(NM), .OP_W(OW), .ADDR_W(AW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
      .fetch_ready(fetch_ready), .unit_stall(unit_stall), .miss_stall(miss_stall),
      .br_taken(br_taken), .br_target(br_target), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc), .slot_op(slot_op), .slot_vld(slot_vld),
      .global_stall(global_stall), .issued_cnt(issued_cnt), .op_cnt(op_cnt));

   always #10 clk = ~clk;

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      fails++;
      $display("FAIL watchdog: R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   function automatic logic [NS*FW-1:0] pack(logic [NS-1:0] v, logic [OW-1:0] seed);
      logic [NS*FW-1:0] w = '0;
      for (int s = 0; s < NS; s++) begin
         w[s*FW +: OW] = seed ^ (32'h1111_0000 * (s + 1)) ^ OW'(s);
         w[s*FW + OW]  = v[s];
      end
      return w;
   endfunction

   function automatic int popc(logic [NS-1:0] v);
      int n = 0;
      for (int s = 0; s < NS; s++) n += v[s];
      return n;
   endfunction

   task automatic cmp(string req, logic [255:0] act, logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // apply one vector at the negedge, check before posedge, advance model
   task automatic step(string req, logic fv, logic [NS*FW-1:0] w,
                       logic [NS-1:0] us, logic [NM-1:0] ms,
                       logic br, logic [AW-1:0] tgt);
      logic st;
      logic [NS-1:0] ev;
      logic [NS*OW-1:0] eop;
      fetch_valid = fv; fetch_word = w; unit_stall = us; miss_stall = ms;
      br_taken = br; br_target = tgt;
      #4;
      st = (|us) || (|ms);
      for (int s = 0; s < NS; s++) begin
         ev[s] = m_v[s] && !st;
         eop[s*OW +: OW] = m_v[s] ? m_op[s] : '0;
      end
      cmp({req, " R4/R5 global_stall"}, 256'(global_stall), 256'(st));
      cmp({req, " R6 fetch_ready"}, 256'(fetch_ready), 256'(!st));
      cmp({req, " R2/R3 slot_vld"}, 256'(slot_vld), 256'(ev));
      cmp({req, " R2/R3 slot_op"}, 256'(slot_op), 256'(eop));
      cmp({req, " R7 redirect_valid"}, 256'(redirect_valid), 256'(br && !st));
      if (br && !st) cmp({req, " R7 redirect_pc"}, 256'(redirect_pc), 256'(tgt));
      cmp({req, " R8 issued_cnt"}, 256'(issued_cnt), 256'(m_iss));
      cmp({req, " R8 op_cnt"}, 256'(op_cnt), 256'(m_ops));
      @(posedge clk);
      if (!st) begin
         if (|ev) begin
            m_iss = m_iss + CW'(1);
            m_ops = m_ops + CW'(popc(ev));
         end
         for (int s = 0; s < NS; s++) begin
            m_v[s]  = fv && !br && w[s*FW + OW];
            m_op[s] = (fv && !br) ? w[s*FW +: OW] : '0;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] r;
      r = $urandom(32'd4242);
      for (int s = 0; s < NS; s++) m_op[s] = '0;
      m_v = '0; m_iss = '0; m_ops = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      cmp("R1 slot_vld", 256'(slot_vld), 256'(0));
      cmp("R1 slot_op", 256'(slot_op), 256'(0));
      cmp("R1 issued_cnt", 256'(issued_cnt), 256'(0));
      cmp("R1 op_cnt", 256'(op_cnt), 256'(0));
      rst_n = 1;

      // R2 full word, then empty word (R3), then mixed
      step("R2 full", 1, pack(5'b11111, 32'hA5A5_0001), '0, '0, 0, '0);
      step("R3 empty", 1, pack(5'b00000, 32'hDEAD_BEEF), '0, '0, 0, '0);
      step("R2 mixed", 1, pack(5'b10101, 32'h0BAD_F00D), '0, '0, 0, '0);
      // R4 multi-cycle unit stall holds the mixed word
      step("R4 stall", 1, pack(5'b11111, 32'h1234_5678), 5'b00100, '0, 0, '0);
      step("R4 stall", 1, pack(5'b11111, 32'h1234_5678), 5'b10000, '0, 0, '0);
      step("R4 release", 1, pack(5'b01010, 32'h5555_AAAA), '0, '0, 0, '0);
      // R5 miss stall
      step("R5 miss", 0, '0, '0, 2'b10, 0, '0);
      step("R5 miss", 0, '0, '0, 2'b01, 0, '0);
      // R6 bubble
      step("R6 bubble", 0, pack(5'b11111, 32'h7777_7777), '0, '0, 0, '0);
      step("R6 after", 1, pack(5'b11111, 32'h3333_0000), '0, '0, 0, '0);
      // R7 branch free and during stall
      step("R7 branch", 1, pack(5'b11111, 32'h9999_0000), '0, '0, 1, 32'h0000_4000);
      step("R7 flushed", 1, pack(5'b00111, 32'h8888_0000), '0, '0, 0, '0);
      step("R7 stalled br", 1, pack(5'b11111, 32'h6666_0000), 5'b00001, '0, 1, 32'h0000_8000);
      step("R7 kept", 0, '0, '0, '0, 0, '0);

      // random mix; CW=6 makes the counters wrap (R8)
      for (int k = 0; k < 1500; k++) begin
         logic [NS-1:0] us, v;
         logic [NM-1:0] ms;
         us = ($urandom_range(0, 9) < 2) ? NS'(1 << $urandom_range(0, NS - 1)) : '0;
         ms = ($urandom_range(0, 9) < 1) ? NM'($urandom_range(1, 3)) : '0;
         v  = NS'($urandom);
         step("R8 random", $urandom_range(0, 9) < 8, pack(v, $urandom), us, ms,
              $urandom_range(0, 9) < 1, $urandom);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule